// File: doc/BRIEF.md
# SDRAM Refresh Command Unit

This block watches the SDRAM control pins on every rising clock edge and picks out the two refresh requests: auto refresh and self-refresh entry. It holds the internal refresh address counter, so the controller never supplies a row or a bank for a refresh. Each accepted refresh emits a one-cycle pulse together with the row and bank it used. The counter then steps to the next bank, and after the last bank it moves to the next row.

A refresh is accepted only when every bank reports that it is precharged. If any bank is still open, the request is rejected and an error pulse is raised. After an auto refresh the unit stays busy for a fixed, parameterised number of cycles. The banks fall back to idle on their own at the end of that window, with no precharge command needed. Any command other than NOP that arrives while the unit is busy is rejected and flagged as an error.

Self refresh is tracked as a mode. While the unit is in this mode, an internal tick drives the refreshes and the command pins are ignored. Raising CKE ends the mode.

Top module: `srf_refresh_unit`

## Requirements
- R1: While reset is high and after it is released, ref_pulse, err, busy and self_ref are 0, and the next refresh uses bank 0, row 0.
- R2: An auto refresh is a sampled edge with cke=1, ras_n=0, cas_n=0 and we_n=1, while the unit is idle, not busy, and all bank_idle bits are 1. One cycle after that edge, ref_pulse is 1 for exactly one cycle, and ref_bank/ref_row show the counter value that was used.
- R3: If any bank_idle bit is 0 when an auto refresh or a self-refresh entry is requested, the request is rejected. The cycle after the edge has err=1 and ref_pulse=0, the counter does not move, and self_ref stays 0.
- R4: The counter advances once per refresh. The bank steps first (0 to NUM_BANKS-1). After the last bank it returns to 0 and the row goes up by one. After the last row of the last bank, both wrap to 0.
- R5: The refresh bank comes from the internal counter only. The unit has no bank-address input.
- R6: After an auto refresh, busy is 1 for BUSY_CYC cycles. A NOP (ras_n=cas_n=we_n=1) during that window is accepted silently. Any other pin pattern sampled while busy is 1 gives err=1 the next cycle and has no other effect.
- R7: A self-refresh entry is the refresh pin pattern with cke=0, while the unit is idle and not busy, and all banks are precharged. The next cycle has self_ref=1, and the entry itself makes no ref_pulse and no err.
- R8: In self refresh, every edge with sr_tick=1 and cke=0 makes one refresh: ref_pulse is 1 the next cycle and the counter advances. All command pins and bank_idle are ignored in this mode. sr_tick has no effect outside self refresh.
- R9: An edge with cke=1 in self refresh returns the unit to idle (self_ref=0 the next cycle). A tick on that same edge is ignored.
- R10: Outside self refresh and the busy window, pin patterns other than the two refresh encodings give no pulse, no error and no counter change.
- R11: err is a registered pulse that is high only in the cycle after the offending edge, and it is never high together with ref_pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; pins are sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock-enable pin level |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank_idle | input | NUM_BANKS | One bit per bank, 1 when the bank is precharged |
| sr_tick | input | 1 | Internal refresh tick used during self refresh |
| ref_pulse | output | 1 | One-cycle pulse for each refresh performed |
| ref_bank | output | BANK_W | Bank used by the most recent refresh |
| ref_row | output | ROW_BITS | Row used by the most recent refresh |
| busy | output | 1 | High during the window after an auto refresh |
| self_ref | output | 1 | High while in self-refresh mode |
| err | output | 1 | One-cycle protocol error pulse |

## Verification
Some properties are checked on every cycle. The counter order (bank before row, and the bank wrapping into a row step) is checked this way. So are these: no refresh pulse in the cycle after busy was seen, an auto-refresh pulse always paired with busy and with all banks idle on the edge before, a mode exit whenever CKE is sampled high in self refresh, and err never coinciding with ref_pulse. Other behaviour can only be shown by the bench's scenarios. These are the exact address sequence across the full row-and-bank wrap, and the rejection of non-refresh commands and of self-refresh entry inside the busy window. The bench also shows that ticks do nothing outside self refresh and that a reset in the middle of a busy window clears the unit.

// File: rtl/srf_pkg.sv
package srf_pkg;

    // Pin pattern {ras_n, cas_n, we_n} that requests a refresh
    localparam logic [2:0] PINS_REFRESH = 3'b001;
    // Pin pattern for no operation
    localparam logic [2:0] PINS_NOP     = 3'b111;

    typedef enum logic [1:0] {
        CMD_NOP        = 2'd0,
        CMD_AUTO       = 2'd1,
        CMD_SELF_ENTER = 2'd2,
        CMD_OTHER      = 2'd3
    } cmd_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SELF = 1'b1
    } mode_t;

    typedef struct packed {
        logic go;        // perform one refresh
        logic reject;    // protocol error
        logic load_busy; // start the busy window
    } act_t;

    function automatic int bank_width(input int banks);
        return (banks > 1) ? $clog2(banks) : 1;
    endfunction

    function automatic cmd_t decode_pins(input logic cke, input logic [2:0] pins);
        cmd_t c;
        if (pins == PINS_NOP)
            c = CMD_NOP;
        else if (pins == PINS_REFRESH)
            c = cke ? CMD_AUTO : CMD_SELF_ENTER;
        else
            c = CMD_OTHER;
        return c;
    endfunction

endpackage

// File: rtl/srf_cmd_decode.sv
module srf_cmd_decode
    import srf_pkg::*;
(
    input  logic cke,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_t cmd
);

    logic [2:0] pins;

    assign pins = {ras_n, cas_n, we_n};

    always_comb begin
        cmd = decode_pins(cke, pins);
    end

endmodule

// File: rtl/srf_addr_counter.sv
module srf_addr_counter #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_BITS  = 4,
    parameter int BANK_W    = srf_pkg::bank_width(NUM_BANKS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                adv,
    output logic [BANK_W-1:0]   bank,
    output logic [ROW_BITS-1:0] row
);

    localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(NUM_BANKS - 1);
    localparam bit                BANK_POW2 = ((1 << BANK_W) == NUM_BANKS);

    logic [BANK_W-1:0]   bank_q;
    logic [ROW_BITS-1:0] row_q;
    logic [BANK_W-1:0]   bank_nxt;
    logic                bank_last;

    assign bank_last = (bank_q == LAST_BANK);

    generate
        if (BANK_POW2) begin : g_pow2
            assign bank_nxt = bank_q + 1'b1;
        end else begin : g_mod
            assign bank_nxt = bank_last ? '0 : (bank_q + 1'b1);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= '0;
            row_q  <= '0;
        end else if (adv) begin
            bank_q <= bank_nxt;
            if (bank_last)
                row_q <= row_q + 1'b1;
        end
    end

    assign bank = bank_q;
    assign row  = row_q;

    // R4
    bank_first_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !bank_last) |=> $stable(row_q));

    // R4
    row_step_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && bank_last) |=> (bank_q == '0) && (row_q == ROW_BITS'($past(row_q) + 1'b1)));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !adv |=> ($stable(bank_q) && $stable(row_q)));

endmodule

// File: rtl/srf_ctrl.sv
module srf_ctrl
    import srf_pkg::*;
#(
    parameter int BUSY_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  cmd_t cmd,
    input  logic cke,
    input  logic tick,
    input  logic all_idle,
    output act_t act,
    output logic in_self,
    output logic busy
);

    localparam int BUSY_W = $clog2(BUSY_CYC + 1);

    mode_t             mode_q;
    mode_t             mode_nxt;
    logic [BUSY_W-1:0] busy_cnt;

    always_comb begin
        act      = '0;
        mode_nxt = mode_q;
        if (mode_q == ST_SELF) begin
            if (cke)
                mode_nxt = ST_IDLE;
            else if (tick)
                act.go = 1'b1;
        end else if (busy_cnt != '0) begin
            if (cmd != CMD_NOP)
                act.reject = 1'b1;
        end else begin
            case (cmd)
                CMD_AUTO: begin
                    if (all_idle) begin
                        act.go        = 1'b1;
                        act.load_busy = 1'b1;
                    end else begin
                        act.reject = 1'b1;
                    end
                end
                CMD_SELF_ENTER: begin
                    if (all_idle)
                        mode_nxt = ST_SELF;
                    else
                        act.reject = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= ST_IDLE;
            busy_cnt <= '0;
        end else begin
            mode_q <= mode_nxt;
            if (act.load_busy)
                busy_cnt <= BUSY_W'(BUSY_CYC);
            else if (busy_cnt != '0)
                busy_cnt <= busy_cnt - 1'b1;
        end
    end

    assign in_self = (mode_q == ST_SELF);
    assign busy    = (busy_cnt != '0);

    // R9
    self_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (in_self && cke) |=> !in_self);

    // R6
    busy_no_go_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !act.go);

    // R7
    busy_no_self_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !in_self);

endmodule

// File: rtl/srf_refresh_unit.sv
module srf_refresh_unit
    import srf_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_BITS  = 4,
    parameter int BUSY_CYC  = 3,
    parameter int BANK_W    = srf_pkg::bank_width(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cke,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic [NUM_BANKS-1:0] bank_idle,
    input  logic                 sr_tick,
    output logic                 ref_pulse,
    output logic [BANK_W-1:0]    ref_bank,
    output logic [ROW_BITS-1:0]  ref_row,
    output logic                 busy,
    output logic                 self_ref,
    output logic                 err
);

    cmd_t                cmd;
    act_t                act;
    logic                all_idle;
    logic [BANK_W-1:0]   cnt_bank;
    logic [ROW_BITS-1:0] cnt_row;

    assign all_idle = &bank_idle;

    srf_cmd_decode u_decode (
        .cke   (cke),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    srf_ctrl #(
        .BUSY_CYC (BUSY_CYC)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .cke      (cke),
        .tick     (sr_tick),
        .all_idle (all_idle),
        .act      (act),
        .in_self  (self_ref),
        .busy     (busy)
    );

    srf_addr_counter #(
        .NUM_BANKS (NUM_BANKS),
        .ROW_BITS  (ROW_BITS),
        .BANK_W    (BANK_W)
    ) u_counter (
        .clk  (clk),
        .rst  (rst),
        .adv  (act.go),
        .bank (cnt_bank),
        .row  (cnt_row)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_pulse <= 1'b0;
            err       <= 1'b0;
            ref_bank  <= '0;
            ref_row   <= '0;
        end else begin
            ref_pulse <= act.go;
            err       <= act.reject;
            if (act.go) begin
                ref_bank <= cnt_bank;
                ref_row  <= cnt_row;
            end
        end
    end

    // R3
    precond_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_pulse && !self_ref) |-> $past(all_idle));

    // R6
    busy_after_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_pulse && !self_ref) |-> busy);

    // R6
    busy_block_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> !ref_pulse);

    // R11
    err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> !ref_pulse);

    // R7
    entry_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(self_ref) |-> (!ref_pulse && !err));

    // R8
    tick_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_pulse && self_ref) |-> $past(sr_tick));

endmodule

// File: tb/test_srf_refresh_unit.sv
`timescale 1ns/1ps
module test_srf_refresh_unit;

    localparam int NB  = 4;
    localparam int RB  = 4;
    localparam int BC  = 3;
    localparam int NV  = 23;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cke = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [NB-1:0] bank_idle = '1;
    logic          sr_tick = 1'b0;
    logic          ref_pulse, busy, self_ref, err;
    logic [1:0]    ref_bank;
    logic [RB-1:0] ref_row;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    srf_refresh_unit #(.NUM_BANKS(NB), .ROW_BITS(RB), .BUSY_CYC(BC)) i_srf_refresh_unit (
        .clk(clk), .rst(rst), .cke(cke), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .bank_idle(bank_idle), .sr_tick(sr_tick), .ref_pulse(ref_pulse),
        .ref_bank(ref_bank), .ref_row(ref_row), .busy(busy), .self_ref(self_ref), .err(err)
    );

    // {req, cke ras cas we, idle, tick, pulse err busy self, bank, row}
    localparam logic [22:0] VEC [NV] = '{
        {4'd1,  4'b1111, 4'hF, 1'b0, 4'b0000, 2'd0, 4'd0}, // R1 idle after reset
        {4'd2,  4'b1001, 4'hF, 1'b0, 4'b1010, 2'd0, 4'd0}, // R2 auto refresh
        {4'd6,  4'b1111, 4'hF, 1'b0, 4'b0010, 2'd0, 4'd0}, // R6 NOP while busy
        {4'd6,  4'b1001, 4'hF, 1'b0, 4'b0110, 2'd0, 4'd0}, // R6 refresh while busy
        {4'd6,  4'b1111, 4'hF, 1'b0, 4'b0000, 2'd0, 4'd0}, // R6 window ends
        {4'd3,  4'b1001, 4'hB, 1'b0, 4'b0100, 2'd0, 4'd0}, // R3 open bank
        {4'd5,  4'b1001, 4'hF, 1'b0, 4'b1010, 2'd1, 4'd0}, // R5 counter bank
        {4'd6,  4'b1111, 4'hF, 1'b0, 4'b0010, 2'd1, 4'd0}, // R6
        {4'd6,  4'b1111, 4'hF, 1'b0, 4'b0010, 2'd1, 4'd0}, // R6
        {4'd6,  4'b1111, 4'hF, 1'b0, 4'b0000, 2'd1, 4'd0}, // R6
        {4'd10, 4'b1011, 4'hF, 1'b0, 4'b0000, 2'd1, 4'd0}, // R10 other cmd
        {4'd7,  4'b0001, 4'hF, 1'b0, 4'b0001, 2'd1, 4'd0}, // R7 self entry
        {4'd8,  4'b0111, 4'hF, 1'b1, 4'b1001, 2'd2, 4'd0}, // R8 tick
        {4'd8,  4'b0010, 4'h0, 1'b0, 4'b0001, 2'd2, 4'd0}, // R8 pins ignored
        {4'd8,  4'b0111, 4'hF, 1'b1, 4'b1001, 2'd3, 4'd0}, // R8 tick
        {4'd4,  4'b0111, 4'hF, 1'b1, 4'b1001, 2'd0, 4'd1}, // R4 bank wraps, row steps
        {4'd9,  4'b1111, 4'hF, 1'b1, 4'b0000, 2'd0, 4'd1}, // R9 exit, tick ignored
        {4'd8,  4'b1111, 4'hF, 1'b1, 4'b0000, 2'd0, 4'd1}, // R8 tick outside self
        {4'd3,  4'b0001, 4'h7, 1'b0, 4'b0100, 2'd0, 4'd1}, // R3 entry rejected
        {4'd2,  4'b1001, 4'hF, 1'b0, 4'b1010, 2'd1, 4'd1}, // R2
        {4'd6,  4'b1011, 4'hF, 1'b0, 4'b0110, 2'd1, 4'd1}, // R6 other cmd while busy
        {4'd6,  4'b0001, 4'hF, 1'b0, 4'b0110, 2'd1, 4'd1}, // R6 entry while busy
        {4'd11, 4'b1111, 4'hF, 1'b0, 4'b0000, 2'd1, 4'd1}  // R11 err drops
    };

    task automatic drive(input logic [3:0] p, input logic [3:0] idle, input logic t);
        {cke, ras_n, cas_n, we_n} = p;
        bank_idle = idle;
        sr_tick   = t;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [9:0] exp);
        logic [9:0] act;
        act = {ref_pulse, err, busy, self_ref, ref_bank, ref_row};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b (pulse err busy self bank row)", req, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int mb;
        int mr;
        @(negedge clk);
        @(negedge clk);
        check("R1", 10'b0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][18:15], VEC[i][14:11], VEC[i][10]);
            check($sformatf("R%0d vec%0d", VEC[i][22:19], i), VEC[i][9:0]);
        end

        // R1: reset in the middle of a busy window
        drive(4'b1001, 4'hF, 1'b0);
        check("R2", {4'b1010, 2'd2, 4'd1});
        rst = 1'b1;
        drive(4'b1111, 4'hF, 1'b0);
        check("R1", 10'b0);
        rst = 1'b0;
        drive(4'b1001, 4'hF, 1'b0);
        check("R1", {4'b1010, 2'd0, 4'd0});

        // R4: full wrap through self refresh ticks
        rst = 1'b1;
        drive(4'b1111, 4'hF, 1'b0);
        rst = 1'b0;
        drive(4'b0001, 4'hF, 1'b0);
        check("R7", {4'b0001, 2'd0, 4'd0});
        mb = 0;
        mr = 0;
        for (int k = 0; k < NB * (1 << RB) + 2; k++) begin
            drive(4'b0111, 4'hF, 1'b1);
            check("R4", {4'b1001, mb[1:0], mr[RB-1:0]});
            mb++;
            if (mb == NB) begin
                mb = 0;
                mr = (mr + 1) % (1 << RB);
            end
        end
        drive(4'b1111, 4'hF, 1'b0);
        check("R9", {4'b0000, 2'd1, 4'd0});

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule